// File: doc/BRIEF.md
# Real-Mode Branch Target Resolver

This unit decides where a 16-bit segmented processor fetches next after a control-transfer instruction has been decoded. The decoder gives it a branch kind, a condition code, the immediate bytes that follow the opcode, a register operand, the five arithmetic flags, the count register and the current code segment and offset. The offset it receives is the address of the branch instruction itself. The unit returns the next segment and offset, a flag that says whether the transfer was taken, and the count value that a loop form writes back.

Each kind has its own rule for the target. Relative forms add a sign-extended displacement to the fall-through offset. The far form loads both segment and offset from the immediate. The register form copies the operand into the offset. Conditional forms test the flags. Loop forms decrement the count and test the new value. All offset arithmetic wraps at 16 bits. Results are registered and change only in the cycle after a one-cycle valid strobe, so the fetch unit samples a stable target.

Top module: `branch_resolver`

## Requirements
- R1: A synchronous reset sets the segment output to FFFFh, the offset output to 0000h, the taken flag to 0 and the count output to 0000h.
- R2: Outputs change only on the clock edge that samples valid high. Without valid they hold their values whatever the other inputs do.
- R3: Kind 0 (short) is always taken. The new offset is offset + 2 + sign-extended immediate bits 7:0, modulo 2^16.
- R4: Kind 1 (near) is always taken. The new offset is offset + 3 + immediate bits 15:0, modulo 2^16.
- R5: Kind 2 (far) is always taken. The new offset is immediate bits 15:0 and the new segment is immediate bits 31:16.
- R6: Kind 3 (register) is always taken. The new offset is the register operand with nothing added.
- R7: Kind 4 (conditional) uses a 4-bit condition code: 0 overflow, 1 no overflow, 4 zero, 5 not zero, 8 sign, 9 no sign, 10 parity, 11 no parity. When taken the new offset follows the R3 rule. Otherwise it is offset + 2.
- R8: The signed condition codes are 12 less (S!=O), 13 greater-or-equal (S==O), 14 less-or-equal (Z=1 or S!=O) and 15 greater (Z=0 and S==O).
- R9: The unsigned condition codes are 2 below (C=1), 3 above-or-equal (C=0), 6 below-or-equal (C=1 or Z=1) and 7 above (C=0 and Z=0).
- R10: Kind 5 (loop) outputs count-1, modulo 2^16, and is taken with the R3 target when that value is nonzero. Otherwise it falls through to offset + 2. A count of 0 wraps to FFFFh and is taken.
- R11: Kind 6 (loop while equal) is taken only when count-1 is nonzero and Z=1. Kind 7 (loop while not equal) is taken only when count-1 is nonzero and Z=0. Both output count-1.
- R12: Kinds 0 to 4 pass the count through unchanged. Every kind except far keeps the segment unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | One-cycle strobe: resolve the presented branch |
| kind | input | 3 | Branch kind, encoded as in R3 to R11 |
| cond | input | 4 | Condition code for kind 4 |
| imm | input | 32 | Immediate bytes after the opcode; first byte in bits 7:0 |
| regOp | input | 16 | Register operand for kind 3 |
| flagS | input | 1 | Sign flag |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| flagP | input | 1 | Parity flag |
| flagO | input | 1 | Overflow flag |
| cxIn | input | 16 | Current count register |
| csIn | input | 16 | Current code segment |
| ipIn | input | 16 | Offset of the branch instruction |
| csOut | output | 16 | Next code segment |
| ipOut | output | 16 | Next offset |
| taken | output | 1 | The transfer was taken |
| cxOut | output | 16 | Count value to write back |

## Verification
A wrong strobe from the control half shows up at the ports one cycle after the valid strobe. A mistaken condition gives a fall-through offset where a target was due, or the reverse, and the taken flag disagrees with it. A bad length or displacement select moves the offset by a small constant or by the wrong sign. A stuck output register shows as outputs that move during idle cycles, or that never leave their reset values. Each wrong value lasts until the next strobe, so every vector is checked in the cycle that follows it.

// File: rtl/branch_resolver_pkg.sv
package branch_resolver_pkg;

  typedef enum logic [2:0] {
    KIND_SHORT  = 3'd0,
    KIND_NEAR   = 3'd1,
    KIND_FAR    = 3'd2,
    KIND_REG    = 3'd3,
    KIND_COND   = 3'd4,
    KIND_LOOP   = 3'd5,
    KIND_LOOPZ  = 3'd6,
    KIND_LOOPNZ = 3'd7
  } kind_e;

  typedef enum logic [1:0] {
    TGT_REL8  = 2'd0,
    TGT_REL16 = 2'd1,
    TGT_ABS   = 2'd2,
    TGT_REG   = 2'd3
  } tgtSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       takeIt;
    logic       loadSeg;
    logic       decCx;
    tgtSel_e    tgtSel;
    logic [2:0] instLen;
  } ctrlStrobes_t;

endpackage

// File: rtl/branch_resolver_ctrl.sv
module branch_resolver_ctrl
  import branch_resolver_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   kind,
  input  logic [3:0]   cond,
  input  logic         flagS,
  input  logic         flagZ,
  input  logic         flagC,
  input  logic         flagP,
  input  logic         flagO,
  input  logic [W-1:0] cxIn,
  output ctrlStrobes_t strobes
);

  kind_e kindDec;
  logic  condMet;
  logic  cxLeft;
  logic  signMismatch;

  assign kindDec      = kind_e'(kind);
  assign signMismatch = flagS ^ flagO;
  // count after decrement is nonzero exactly when count is not one
  assign cxLeft       = (cxIn != W'(1));

  always_comb begin
    unique case (cond)
      4'd0:  condMet = flagO;
      4'd1:  condMet = !flagO;
      4'd2:  condMet = flagC;
      4'd3:  condMet = !flagC;
      4'd4:  condMet = flagZ;
      4'd5:  condMet = !flagZ;
      4'd6:  condMet = flagC | flagZ;
      4'd7:  condMet = !(flagC | flagZ);
      4'd8:  condMet = flagS;
      4'd9:  condMet = !flagS;
      4'd10: condMet = flagP;
      4'd11: condMet = !flagP;
      4'd12: condMet = signMismatch;
      4'd13: condMet = !signMismatch;
      4'd14: condMet = flagZ | signMismatch;
      default: condMet = !(flagZ | signMismatch);
    endcase
  end

  always_comb begin
    strobes         = '0;
    strobes.instLen = 3'd2;
    strobes.tgtSel  = TGT_REL8;
    unique case (kindDec)
      KIND_SHORT: strobes.takeIt = 1'b1;
      KIND_NEAR: begin
        strobes.takeIt  = 1'b1;
        strobes.instLen = 3'd3;
        strobes.tgtSel  = TGT_REL16;
      end
      KIND_FAR: begin
        strobes.takeIt  = 1'b1;
        strobes.loadSeg = 1'b1;
        strobes.instLen = 3'd5;
        strobes.tgtSel  = TGT_ABS;
      end
      KIND_REG: begin
        strobes.takeIt = 1'b1;
        strobes.tgtSel = TGT_REG;
      end
      KIND_COND: strobes.takeIt = condMet;
      KIND_LOOP: begin
        strobes.decCx  = 1'b1;
        strobes.takeIt = cxLeft;
      end
      KIND_LOOPZ: begin
        strobes.decCx  = 1'b1;
        strobes.takeIt = cxLeft & flagZ;
      end
      default: begin
        strobes.decCx  = 1'b1;
        strobes.takeIt = cxLeft & !flagZ;
      end
    endcase
  end

endmodule

// File: rtl/branch_resolver_dp.sv
module branch_resolver_dp
  import branch_resolver_pkg::*;
#(
  parameter int           W         = 16,
  parameter logic [W-1:0] RESET_SEG = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid,
  input  ctrlStrobes_t   strobes,
  input  logic [2*W-1:0] imm,
  input  logic [W-1:0]   regOp,
  input  logic [W-1:0]   cxIn,
  input  logic [W-1:0]   csIn,
  input  logic [W-1:0]   ipIn,
  output logic [W-1:0]   csOut,
  output logic [W-1:0]   ipOut,
  output logic           taken,
  output logic [W-1:0]   cxOut
);

  localparam int SHORT_PAD = W - 8;

  logic [W-1:0] fallIp;
  logic [W-1:0] dispExt;
  logic [W-1:0] relIp;
  logic [W-1:0] targetIp;
  logic [W-1:0] nextIp;
  logic [W-1:0] nextCs;
  logic [W-1:0] nextCx;

  assign fallIp  = ipIn + W'(strobes.instLen);
  // one shared adder for both displacement widths
  assign dispExt = (strobes.tgtSel == TGT_REL16) ? imm[W-1:0]
                                                 : {{SHORT_PAD{imm[7]}}, imm[7:0]};
  assign relIp   = fallIp + dispExt;

  always_comb begin
    unique case (strobes.tgtSel)
      TGT_ABS: targetIp = imm[W-1:0];
      TGT_REG: targetIp = regOp;
      default: targetIp = relIp;
    endcase
  end

  assign nextIp = strobes.takeIt ? targetIp : fallIp;
  assign nextCs = (strobes.takeIt && strobes.loadSeg) ? imm[2*W-1:W] : csIn;
  assign nextCx = strobes.decCx ? (cxIn - W'(1)) : cxIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      csOut <= RESET_SEG;
      ipOut <= '0;
      taken <= 1'b0;
      cxOut <= '0;
    end else if (valid) begin
      csOut <= nextCs;
      ipOut <= nextIp;
      taken <= strobes.takeIt;
      cxOut <= nextCx;
    end
  end

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import branch_resolver_pkg::*;
#(
  parameter int           W         = 16,
  parameter logic [W-1:0] RESET_SEG = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid,
  input  logic [2:0]     kind,
  input  logic [3:0]     cond,
  input  logic [2*W-1:0] imm,
  input  logic [W-1:0]   regOp,
  input  logic           flagS,
  input  logic           flagZ,
  input  logic           flagC,
  input  logic           flagP,
  input  logic           flagO,
  input  logic [W-1:0]   cxIn,
  input  logic [W-1:0]   csIn,
  input  logic [W-1:0]   ipIn,
  output logic [W-1:0]   csOut,
  output logic [W-1:0]   ipOut,
  output logic           taken,
  output logic [W-1:0]   cxOut
);

  ctrlStrobes_t strobes;

  branch_resolver_ctrl #(.W(W)) u_ctrl (
    .kind(kind), .cond(cond),
    .flagS(flagS), .flagZ(flagZ), .flagC(flagC), .flagP(flagP), .flagO(flagO),
    .cxIn(cxIn), .strobes(strobes)
  );

  branch_resolver_dp #(.W(W), .RESET_SEG(RESET_SEG)) u_dp (
    .clk(clk), .rst(rst), .valid(valid), .strobes(strobes),
    .imm(imm), .regOp(regOp), .cxIn(cxIn), .csIn(csIn), .ipIn(ipIn),
    .csOut(csOut), .ipOut(ipOut), .taken(taken), .cxOut(cxOut)
  );

endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           valid,
  input logic [2:0]     kind,
  input logic [2*W-1:0] imm,
  input logic [W-1:0]   regOp,
  input logic [W-1:0]   cxIn,
  input logic [W-1:0]   csIn,
  input logic [W-1:0]   ipIn,
  input logic [W-1:0]   csOut,
  input logic [W-1:0]   ipOut,
  input logic           taken,
  input logic [W-1:0]   cxOut
);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(csOut) && $stable(ipOut) && $stable(taken) && $stable(cxOut)));

  assert_far_load_R5: assert property (@(posedge clk) disable iff (rst)
    (valid && kind == 3'd2) |=> (taken && ipOut == $past(imm[W-1:0]) && csOut == $past(imm[2*W-1:W])));

  assert_reg_copy_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && kind == 3'd3) |=> (taken && ipOut == $past(regOp)));

  assert_loop_exit_R10: assert property (@(posedge clk) disable iff (rst)
    (valid && kind >= 3'd5 && cxIn == W'(1)) |=> (!taken && ipOut == $past(ipIn) + W'(2) && cxOut == '0));

  assert_loop_dec_R11: assert property (@(posedge clk) disable iff (rst)
    (valid && kind >= 3'd5) |=> (cxOut == $past(cxIn) - W'(1)));

  assert_cx_pass_R12: assert property (@(posedge clk) disable iff (rst)
    (valid && kind <= 3'd4) |=> (cxOut == $past(cxIn)));

  assert_seg_keep_R12: assert property (@(posedge clk) disable iff (rst)
    (valid && kind != 3'd2) |=> (csOut == $past(csIn)));

endmodule

bind branch_resolver branch_resolver_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .valid(valid), .kind(kind), .imm(imm), .regOp(regOp),
  .cxIn(cxIn), .csIn(csIn), .ipIn(ipIn),
  .csOut(csOut), .ipOut(ipOut), .taken(taken), .cxOut(cxOut)
);

// File: tb/sim_branch_resolver.sv
module sim_branch_resolver;

  typedef struct {
    logic [15:0] cs;
    logic [15:0] ip;
    logic        tk;
    logic [15:0] cx;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [2:0]  kind = '0;
  logic [3:0]  cond = '0;
  logic [31:0] imm = '0;
  logic [15:0] regOp = '0;
  logic        flagS = 1'b0, flagZ = 1'b0, flagC = 1'b0, flagP = 1'b0, flagO = 1'b0;
  logic [15:0] cxIn = '0, csIn = '0, ipIn = '0;
  logic [15:0] csOut, ipOut, cxOut;
  logic        taken;

  exp_t expQ[$];
  exp_t lastExp;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  branch_resolver u0 (
    .clk(clk), .rst(rst), .valid(valid), .kind(kind), .cond(cond), .imm(imm),
    .regOp(regOp), .flagS(flagS), .flagZ(flagZ), .flagC(flagC), .flagP(flagP),
    .flagO(flagO), .cxIn(cxIn), .csIn(csIn), .ipIn(ipIn),
    .csOut(csOut), .ipOut(ipOut), .taken(taken), .cxOut(cxOut)
  );

  // flags packed as {S,Z,C,P,O}
  function automatic logic condTrue(input logic [3:0] c, input logic [4:0] f);
    logic s, z, cy, p, o;
    {s, z, cy, p, o} = f;
    case (c)
      4'd0:  return o;
      4'd1:  return !o;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return z;
      4'd5:  return !z;
      4'd6:  return cy || z;
      4'd7:  return !cy && !z;
      4'd8:  return s;
      4'd9:  return !s;
      4'd10: return p;
      4'd11: return !p;
      4'd12: return s != o;
      4'd13: return s == o;
      4'd14: return z || (s != o);
      default: return !z && (s == o);
    endcase
  endfunction

  task automatic compare(input exp_t e);
    nChecks++;
    if (csOut !== e.cs || ipOut !== e.ip || taken !== e.tk || cxOut !== e.cx) begin
      nFails++;
      $display("FAIL %s: got cs=%h ip=%h tk=%0b cx=%h, expected cs=%h ip=%h tk=%0b cx=%h",
               e.tag, csOut, ipOut, taken, cxOut, e.cs, e.ip, e.tk, e.cx);
    end
  endtask

  // driver: present one branch, push its expected result
  task automatic apply(input logic [2:0] k, input logic [3:0] c, input logic [31:0] im,
                       input logic [15:0] r, input logic [4:0] f, input logic [15:0] cx,
                       input logic [15:0] cs, input logic [15:0] ip, input string tag);
    exp_t e;
    logic [15:0] fall, rel8, ncx;
    fall = ip + ((k == 3'd1) ? 16'd3 : (k == 3'd2) ? 16'd5 : 16'd2);
    rel8 = fall + {{8{im[7]}}, im[7:0]};
    ncx  = cx - 16'd1;
    e.cs = cs; e.cx = cx; e.tk = 1'b1; e.ip = rel8; e.tag = tag;
    case (k)
      3'd1: e.ip = fall + im[15:0];
      3'd2: begin e.ip = im[15:0]; e.cs = im[31:16]; end
      3'd3: e.ip = r;
      3'd4: e.tk = condTrue(c, f);
      3'd5: begin e.cx = ncx; e.tk = (ncx != 0); end
      3'd6: begin e.cx = ncx; e.tk = (ncx != 0) && f[3]; end
      3'd7: begin e.cx = ncx; e.tk = (ncx != 0) && !f[3]; end
      default: ;
    endcase
    if (!e.tk) e.ip = fall;
    kind = k; cond = c; imm = im; regOp = r;
    {flagS, flagZ, flagC, flagP, flagO} = f;
    cxIn = cx; csIn = cs; ipIn = ip;
    valid = 1'b1;
    expQ.push_back(e);
    @(negedge clk);
    valid = 1'b0;
  endtask

  // monitor: compare one cycle after each sampled strobe
  initial begin
    forever begin
      @(posedge clk);
      if (valid && !rst) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          nChecks++; nFails++;
          $display("FAIL R2: output update with no queued item, got ip=%h expected none", ipOut);
        end else begin
          lastExp = expQ.pop_front();
          compare(lastExp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    exp_t rstExp;
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rstExp.cs = 16'hFFFF; rstExp.ip = 16'h0000; rstExp.tk = 1'b0; rstExp.cx = 16'h0000;
    rstExp.tag = "R1 reset values";
    compare(rstExp);

    // R3 short forward and backward with wrap
    apply(3'd0, 4'd0, 32'h0000_0004, 16'h0, 5'b0, 16'h0005, 16'h1000, 16'h0100, "R3 short +4");
    apply(3'd0, 4'd0, 32'h0000_0080, 16'h0, 5'b0, 16'h0005, 16'h1000, 16'h0010, "R3 short -128 wrap");
    // R4 near, including wrap past FFFFh
    apply(3'd1, 4'd0, 32'h0000_0002, 16'h0, 5'b0, 16'h0007, 16'h2000, 16'h0200, "R4 near +2");
    apply(3'd1, 4'd0, 32'h0000_0100, 16'h0, 5'b0, 16'h0007, 16'h2000, 16'hFF80, "R4 near wrap");
    // R5 far
    apply(3'd2, 4'd0, 32'hA300_0127, 16'h0, 5'b0, 16'h0009, 16'h1000, 16'h0005, "R5 far");
    // R6 register
    apply(3'd3, 4'd0, 32'h0000_00FF, 16'hBEEF, 5'b0, 16'h0003, 16'h3000, 16'h0040, "R6 register");
    // R7 flag tests (flags {S,Z,C,P,O})
    apply(3'd4, 4'd2, 32'h0000_0010, 16'h0, 5'b00100, 16'h1, 16'h4000, 16'h0300, "R9 below taken");
    apply(3'd4, 4'd2, 32'h0000_0010, 16'h0, 5'b00000, 16'h1, 16'h4000, 16'h0300, "R9 below not taken");
    apply(3'd4, 4'd10, 32'h0000_00F0, 16'h0, 5'b00010, 16'h1, 16'h4000, 16'h0300, "R7 parity taken");
    apply(3'd4, 4'd0, 32'h0000_0020, 16'h0, 5'b00000, 16'h1, 16'h4000, 16'h0300, "R7 overflow not taken");
    apply(3'd4, 4'd5, 32'h0000_0020, 16'h0, 5'b01000, 16'h1, 16'h4000, 16'h0300, "R7 not zero with Z=1");
    // R8 signed
    apply(3'd4, 4'd15, 32'h0000_0008, 16'h0, 5'b10001, 16'h1, 16'h4000, 16'h0500, "R8 greater S==O");
    apply(3'd4, 4'd15, 32'h0000_0008, 16'h0, 5'b11001, 16'h1, 16'h4000, 16'h0500, "R8 greater with Z");
    apply(3'd4, 4'd12, 32'h0000_0008, 16'h0, 5'b10000, 16'h1, 16'h4000, 16'h0500, "R8 less S!=O");
    apply(3'd4, 4'd14, 32'h0000_0008, 16'h0, 5'b01000, 16'h1, 16'h4000, 16'h0500, "R8 less-or-equal Z");
    apply(3'd4, 4'd13, 32'h0000_0008, 16'h0, 5'b00001, 16'h1, 16'h4000, 16'h0500, "R8 greater-or-equal false");
    // R9 unsigned
    apply(3'd4, 4'd7, 32'h0000_0008, 16'h0, 5'b00000, 16'h1, 16'h4000, 16'h0600, "R9 above");
    apply(3'd4, 4'd6, 32'h0000_0008, 16'h0, 5'b01000, 16'h1, 16'h4000, 16'h0600, "R9 below-or-equal Z");
    apply(3'd4, 4'd3, 32'h0000_0008, 16'h0, 5'b00100, 16'h1, 16'h4000, 16'h0600, "R9 above-or-equal false");
    // R10 loop
    apply(3'd5, 4'd0, 32'h0000_00FA, 16'h0, 5'b0, 16'h0003, 16'h5000, 16'h0700, "R10 loop taken");
    apply(3'd5, 4'd0, 32'h0000_00FA, 16'h0, 5'b0, 16'h0001, 16'h5000, 16'h0700, "R10 loop exit");
    apply(3'd5, 4'd0, 32'h0000_00FA, 16'h0, 5'b0, 16'h0000, 16'h5000, 16'h0700, "R10 loop count wrap");
    // R11 conditional loops
    apply(3'd6, 4'd0, 32'h0000_00F0, 16'h0, 5'b01000, 16'h0004, 16'h5000, 16'h0800, "R11 loopz taken");
    apply(3'd6, 4'd0, 32'h0000_00F0, 16'h0, 5'b00000, 16'h0004, 16'h5000, 16'h0800, "R11 loopz Z=0 exit");
    apply(3'd7, 4'd0, 32'h0000_00F0, 16'h0, 5'b00000, 16'h0004, 16'h5000, 16'h0800, "R11 loopnz taken");
    apply(3'd7, 4'd0, 32'h0000_00F0, 16'h0, 5'b00000, 16'h0001, 16'h5000, 16'h0800, "R11 loopnz count exit");
    // R12 sweep all kinds and conditions with varied operands
    lf = 16'hACE1;
    for (int i = 0; i < 48; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      apply(3'(i % 8), 4'(i % 16), {lf, ~lf}, lf ^ 16'h5A5A, lf[4:0],
            lf ^ 16'h00FF, lf + 16'd7, ~lf, "R12 sweep");
    end
    // R2 idle: change every input, outputs must hold
    @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      kind = 3'(j); cond = 4'(j); imm = 32'h1234_5678 + 32'(j);
      regOp = 16'h7777; cxIn = 16'h0002; csIn = 16'h9999; ipIn = 16'h4444;
      {flagS, flagZ, flagC, flagP, flagO} = 5'b11111;
      @(negedge clk);
      lastExp.tag = "R2 hold without valid";
      compare(lastExp);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule